// File: doc/BRIEF.md
# Punctured Convolutional Encoder

This block sits in an OFDM WLAN transmit chain between the scrambler and the interleaver. It takes scrambled data one bit at a time and encodes each bit with a rate-1/2 convolutional code. The code has constraint length 7 and produces two coded bits per input bit. A puncturing stage then drops some of these coded bits, so that a single encoder core can deliver a code rate of 1/2, 3/4 or 9/16. The coded bits leave as a serial stream in a fixed order, which the interleaver relies on.

A frame begins with a one-cycle `start` pulse. The pulse clears the encoder memory and the puncturing phase, and it captures the rate for the whole frame. Data bits then arrive over a valid/ready handshake. A one-cycle `flush` pulse makes the block encode six zero tail bits on its own, which returns the encoder memory to all-zero. Backpressure from the interleaver stalls the block without any loss of bits.

Top module: `conv_punct_enc`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Each input bit d forms a window with the six previous bits. Coded bit A is the parity of the taps at delays 0,2,3,5,6 (generator 133 octal). Coded bit B is the parity of the taps at delays 0,1,2,3,6 (generator 171 octal). A kept A is emitted before a kept B of the same input bit.
- R3: `rate_sel` is sampled only in the `start` cycle, with the encoding 0 = 1/2, 1 = 3/4, 2 = 9/16, and 3 = 1/2. A change of `rate_sel` during a frame has no effect on the output.
- R4: At rate 1/2, every A and B bit is emitted.
- R5: At rate 3/4, the phase runs 0..2 per input bit. Phase 0 keeps A and B, phase 1 keeps only A, and phase 2 keeps only B.
- R6: At rate 9/16, the phase runs 0..8 per input bit. Phases 3 and 7 keep only A, and every other phase keeps A and B. This gives 16 of 18 bits.
- R7: `start` clears the encoder memory, the puncturing phase, any pending output and any tail in progress. While `start` is high, `in_ready` is 0.
- R8: A `flush` pulse, given while no tail is running, encodes six zero bits. These bits are punctured with the running phase. While the tail runs, `in_ready` is 0, and the memory is all-zero when the tail ends. A bit accepted in the same cycle as `flush` is encoded before the tail.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_bit` hold. No coded bit is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Frame start pulse, clears state and captures rate |
| rate_sel | input | 2 | Code rate select, sampled at start |
| flush | input | 1 | Request to encode the six-bit zero tail |
| in_valid | input | 1 | Input data bit valid |
| in_bit | input | 1 | Scrambled input data bit |
| in_ready | output | 1 | Encoder can accept an input bit |
| out_valid | output | 1 | Coded bit valid |
| out_bit | output | 1 | Coded bit |
| out_ready | input | 1 | Downstream accepts the coded bit |

## Verification
The bench drives frames at every rate, including the aliased code 3. Each frame has its own length, which moves the phase at which it stops. A design that fails to reset the phase at `start` would then shift the puncturing pattern of the next frame. One frame skips the tail and is followed at once by a new frame, so any memory left behind by `start` corrupts the first coded bits. The bench changes `rate_sel` in the middle of a frame, which exposes a rate that is not held for the frame. It applies random backpressure and checks that a stalled bit holds. A serializer that advances during a stall, or that emits B before A, produces a mismatch in the scoreboard.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
  typedef enum logic [1:0] {
    RATE_HALF  = 2'd0,
    RATE_3Q    = 2'd1,
    RATE_9_16  = 2'd2,
    RATE_ALIAS = 2'd3
  } rate_e;

  localparam int MAX_PERIOD = 9;
  localparam int PH_W = $clog2(MAX_PERIOD);

  // number of input bits before the keep pattern repeats
  function automatic logic [PH_W-1:0] period_of(rate_e r);
    case (r)
      RATE_3Q:   return PH_W'(3);
      RATE_9_16: return PH_W'(9);
      default:   return PH_W'(1);
    endcase
  endfunction

  // keep mask: bit 1 = keep A, bit 0 = keep B
  function automatic logic [1:0] keep_mask(rate_e r, logic [PH_W-1:0] ph);
    logic [1:0] m;
    m = 2'b11;
    case (r)
      RATE_3Q: begin
        if (ph == PH_W'(1)) m = 2'b10;
        else if (ph == PH_W'(2)) m = 2'b01;
      end
      RATE_9_16: begin
        if (ph == PH_W'(3) || ph == PH_W'(7)) m = 2'b10;
      end
      default: m = 2'b11;
    endcase
    return m;
  endfunction

  function automatic logic tap_parity(logic [31:0] win, logic [31:0] poly);
    return ^(win & poly);
  endfunction
endpackage

// File: rtl/cpe_shift_core.sv
module cpe_shift_core #(
  parameter int CONSTR_LEN = 7,
  parameter logic [CONSTR_LEN-1:0] POLY_A = 7'o133,
  parameter logic [CONSTR_LEN-1:0] POLY_B = 7'o171
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic adv,
  input  logic din,
  output logic code_a,
  output logic code_b,
  output logic mem_zero
);
  import cpe_pkg::*;
  localparam int MEM = CONSTR_LEN - 1;

  // mem[MEM-1] is the most recent bit, mem[0] the oldest
  logic [MEM-1:0] mem;
  logic [CONSTR_LEN-1:0] win;

  assign win      = {din, mem};
  assign code_a   = tap_parity(32'(win), 32'(POLY_A));
  assign code_b   = tap_parity(32'(win), 32'(POLY_B));
  assign mem_zero = (mem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mem <= '0;
    else if (clear) mem <= '0;
    else if (adv)   mem <= {din, mem[MEM-1:1]};
  end
endmodule

// File: rtl/cpe_punct_seq.sv
module cpe_punct_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic [1:0] rate_sel,
  input  logic adv,
  output logic [1:0] keep,
  output logic [cpe_pkg::PH_W-1:0] phase
);
  import cpe_pkg::*;

  rate_e rate_q;
  logic [PH_W-1:0] last_ph;

  assign last_ph = period_of(rate_q) - PH_W'(1);
  assign keep    = keep_mask(rate_q, phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_HALF;
      phase  <= '0;
    end else if (clear) begin
      rate_q <= rate_e'(rate_sel);
      phase  <= '0;
    end else if (adv) begin
      phase <= (phase == last_ph) ? '0 : phase + PH_W'(1);
    end
  end
endmodule

// File: rtl/cpe_serializer.sv
module cpe_serializer (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load,
  input  logic a_in,
  input  logic b_in,
  input  logic [1:0] keep,
  input  logic out_ready,
  output logic out_valid,
  output logic out_bit,
  output logic empty
);
  logic [1:0] pend;
  logic a_q, b_q;

  assign empty     = (pend == 2'b00);
  assign out_valid = !empty;
  assign out_bit   = pend[1] ? a_q : b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 2'b00;
      a_q  <= 1'b0;
      b_q  <= 1'b0;
    end else if (clear) begin
      pend <= 2'b00;
    end else if (load) begin
      pend <= keep;
      a_q  <= a_in;
      b_q  <= b_in;
    end else if (out_valid && out_ready) begin
      if (pend[1]) pend[1] <= 1'b0;
      else         pend[0] <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_punct_enc.sv
module conv_punct_enc #(
  parameter int CONSTR_LEN = 7,
  parameter logic [CONSTR_LEN-1:0] POLY_A = 7'o133,
  parameter logic [CONSTR_LEN-1:0] POLY_B = 7'o171
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] rate_sel,
  input  logic       flush,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       in_ready,
  output logic       out_valid,
  output logic       out_bit,
  input  logic       out_ready
);
  import cpe_pkg::*;
  localparam int TAIL_LEN = CONSTR_LEN - 1;
  localparam int TAIL_W   = $clog2(TAIL_LEN + 1);

  logic [TAIL_W-1:0] tail_cnt;
  logic tail_active, slot_free, tail_step, in_fire, load_pair;
  logic enc_din, code_a, code_b, sr_zero;
  logic [1:0] keep;
  logic [PH_W-1:0] phase;

  assign tail_active = (tail_cnt != '0);
  assign in_ready    = slot_free && !tail_active && !start;
  assign tail_step   = slot_free && tail_active && !start;
  assign in_fire     = in_valid && in_ready;
  assign load_pair   = in_fire || tail_step;
  assign enc_din     = tail_active ? 1'b0 : in_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      tail_cnt <= '0;
    else if (start)                  tail_cnt <= '0;
    else if (flush && !tail_active)  tail_cnt <= TAIL_W'(TAIL_LEN);
    else if (tail_step)              tail_cnt <= tail_cnt - TAIL_W'(1);
  end

  cpe_shift_core #(.CONSTR_LEN(CONSTR_LEN), .POLY_A(POLY_A), .POLY_B(POLY_B)) u_core (
    .clk(clk), .rst_n(rst_n), .clear(start), .adv(load_pair), .din(enc_din),
    .code_a(code_a), .code_b(code_b), .mem_zero(sr_zero)
  );

  cpe_punct_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clear(start), .rate_sel(rate_sel),
    .adv(load_pair), .keep(keep), .phase(phase)
  );

  cpe_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .clear(start), .load(load_pair),
    .a_in(code_a), .b_in(code_b), .keep(keep), .out_ready(out_ready),
    .out_valid(out_valid), .out_bit(out_bit), .empty(slot_free)
  );
endmodule

// File: rtl/cpe_checker.sv
module cpe_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic tail_active,
  input logic sr_zero,
  input logic load,
  input logic [1:0] keep,
  input logic [cpe_pkg::PH_W-1:0] phase
);
  import cpe_pkg::*;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !start |=> out_valid && $stable(out_bit)); // R9
  AST_TAIL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    tail_active |-> !in_ready); // R8
  AST_TAIL_ENDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tail_active) |-> sr_zero); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !out_valid && sr_zero && phase == '0); // R7
  AST_START_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !in_ready); // R7
  AST_KEEP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> keep != 2'b00); // R6
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PH_W'(MAX_PERIOD)); // R5
endmodule

bind conv_punct_enc cpe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
  .tail_active(tail_active), .sr_zero(sr_zero), .load(load_pair),
  .keep(keep), .phase(phase)
);

// File: tb/conv_punct_enc_test.sv
module conv_punct_enc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready, out_valid, out_bit;
  logic out_ready = 1'b1;

  always #10 clk = ~clk;

  conv_punct_enc uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_sel(rate_sel), .flush(flush),
    .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .out_valid(out_valid), .out_bit(out_bit), .out_ready(out_ready)
  );

  typedef struct { bit val; string tag; } exp_t;
  exp_t sb[$];

  int n_checks = 0;
  int n_fail = 0;
  bit [5:0] m_hist;
  int m_rate;
  int m_ph;
  string cur_tag;
  bit [15:0] lfsr = 16'hACE1;
  int ready_mode = 0;
  bit done = 0;

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // model: delays counted with hist[5] as one bit ago
  task automatic model_bit(bit d, string tag);
    bit a, b, ka, kb;
    int per;
    a = d ^ m_hist[4] ^ m_hist[3] ^ m_hist[1] ^ m_hist[0];
    b = d ^ m_hist[5] ^ m_hist[4] ^ m_hist[3] ^ m_hist[0];
    ka = 1; kb = 1; per = 1;
    if (m_rate == 1) begin
      per = 3;
      if (m_ph == 1) kb = 0;
      if (m_ph == 2) ka = 0;
    end else if (m_rate == 2) begin
      per = 9;
      if (m_ph == 3 || m_ph == 7) kb = 0;
    end
    if (ka) sb.push_back('{a, tag});
    if (kb) sb.push_back('{b, tag});
    m_hist = {d, m_hist[5:1]};
    m_ph = (m_ph + 1) % per;
  endtask

  task automatic frame_start(int r);
    @(negedge clk);
    start = 1'b1;
    rate_sel = 2'(r);
    @(posedge clk);
    #1;
    start = 1'b0;
    m_hist = '0;
    m_ph = 0;
    m_rate = (r == 3) ? 0 : r;
  endtask

  task automatic send_bit(bit d);
    @(negedge clk);
    in_valid = 1'b1;
    in_bit = d;
    while (!in_ready) @(negedge clk);
    model_bit(d, cur_tag);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1;
    flush = 1'b0;
    for (int i = 0; i < 6; i++) model_bit(1'b0, "R8 tail");
    @(negedge clk);
    check(in_ready == 1'b0, "R8 in_ready during tail", in_ready, 0);
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((sb.size() != 0 || out_valid) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    check(sb.size() == 0 && !out_valid, {cur_tag, " frame length"}, sb.size(), 0);
  endtask

  task automatic run_frame(int r, int n, string tag, bit with_flush, int change_at);
    frame_start(r);
    cur_tag = tag;
    for (int i = 0; i < n; i++) begin
      if (i == change_at) begin
        rate_sel = 2'((r + 1) % 3);
        cur_tag = "R3 mid-frame rate change";
      end
      send_bit(rnd());
    end
    if (with_flush) do_flush();
    drain();
  endtask

  // monitor: choose ready, then compare what the next edge consumes
  bit prev_stall = 0;
  bit prev_bit = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_stall)
        check(out_valid && out_bit == prev_bit, "R9 stalled bit held", int'(out_bit), int'(prev_bit));
      out_ready = (ready_mode == 0) ? 1'b1 : rnd();
      prev_stall = out_valid && !out_ready && !start;
      prev_bit = out_bit;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(0, "R9 unexpected coded bit", int'(out_bit), -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_bit == e.val, e.tag, int'(out_bit), int'(e.val));
        end
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 150000 && !done) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    run_frame(0, 20, "R2/R4 rate 1/2", 1, -1);
    run_frame(1, 22, "R5 rate 3/4", 1, -1);
    run_frame(2, 31, "R6 rate 9/16", 1, -1);
    ready_mode = 1;
    run_frame(1, 17, "R5/R9 rate 3/4 stalled", 1, -1);
    run_frame(2, 25, "R6/R9 rate 9/16 stalled", 0, -1);
    // no tail before: start must clear memory and phase
    run_frame(2, 20, "R7 restart after untailed frame", 1, -1);
    run_frame(3, 12, "R3 alias code", 1, -1);
    run_frame(1, 24, "R5 rate 3/4", 1, 10);
    ready_mode = 0;
    run_frame(0, 9, "R4 rate 1/2 short", 0, -1);
    run_frame(2, 13, "R7 restart rate 9/16", 1, -1);

    @(negedge clk);
    start = 1'b1;
    #1;
    check(in_ready == 1'b0, "R7 in_ready during start", in_ready, 0);
    @(posedge clk);
    #1 start = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule